// File: doc/BRIEF.md
# Two-Level DMA Channel Arbiter

This block decides which DMA channel the transfer engine starts next. The channels are arranged in groups. Arbitration happens in two stages within one cycle. The first stage picks a group from the groups that have at least one pending request. The second stage picks a channel inside that group. Each stage has its own policy input, so either stage can run as fixed priority or as round robin. In fixed priority the larger programmed level wins. In round robin the search starts just after the index that was last granted.

Only one channel is active at a time. A grant holds until the engine reports `done`. The block then returns to idle, and a new arbitration takes place on the next cycle. Starts can be held back in three ways:
- a sticky halt flag, which can also be set automatically on errors;
- a debug stall input, which acts only while its enable is set;
- a configuration error, raised when fixed priority is selected at a stage whose priority levels are not unique.

A channel that links to itself at the end of a minor loop is handled in one of two ways. In continuous mode it restarts at once and skips arbitration. Otherwise its request is reposted and it competes again.

Top module: `dma_grp_arbiter`

## Requirements
- R1: After reset `grant_vld`, `start`, `cfg_err` and `halted` are 0. All round-robin pointers are set so that the first round-robin pick at each stage is index 0.
- R2: With `grp_rr_en`=0, the chosen group is the requesting group with the largest 2-bit level in `grp_pri[g*2 +: 2]`. Group g covers channels g*8 to g*8+7.
- R3: With `ch_rr_en`=0, the channel chosen inside the group is the requesting channel with the largest 3-bit level in `ch_pri[n*3 +: 3]`, where n is the global channel number. `grant_ch` = group*8 + channel index.
- R4: With `grp_rr_en`=1, the chosen group is the first requesting group in ascending circular order after the last granted group. The group pointer moves only when a grant is issued.
- R5: With `ch_rr_en`=1, each group keeps its own pointer. The chosen channel is the first requesting channel after that group's last granted channel, in circular order.
- R6: When idle and not stalled, a pending request leads to `start`=1 and `grant_vld`=1 one cycle later. `start` lasts one cycle. `grant_ch` holds and no other channel starts until `done`. After `done` the block is idle on the next cycle.
- R7: A configuration error occurs when a stage in fixed mode has two equal levels and some request is pending while the block is idle. In that case no grant is issued and `cfg_err` pulses 1 in the following cycle. Duplicate levels at a round-robin stage have no effect.
- R8: `halt_set` sets `halted` and `halt_clr` clears it; set wins over clear. While `halted`=1 no new channel starts. A channel that is already active stays granted until `done`.
- R9: With `hoe_en`=1, a configuration error or an `ext_err` pulse sets `halted` on the same edge. With `hoe_en`=0, errors leave `halted` unchanged.
- R10: While `dbg_en`=1 and `dbg_stall`=1, no new channel starts. Starts resume once either of the two inputs is 0.
- R11: With `clm_en`=1, `done` together with `link_self` restarts the same channel. The next cycle shows `start`=1, `grant_vld`=1 and the same `grant_ch`. There is no arbitration and no pointer change, even if other channels are requesting.
- R12: With `clm_en`=0, `done` together with `link_self` ends the grant and reposts a request for that channel. The reposted request then wins arbitration even if the channel's `req` input is 0, and it is cleared when that channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 32 | Service request, one bit per channel |
| grp_rr_en | input | 1 | 1: round robin among groups, 0: fixed |
| ch_rr_en | input | 1 | 1: round robin inside groups, 0: fixed |
| grp_pri | input | 8 | Group levels, 2 bits per group |
| ch_pri | input | 96 | Channel levels, 3 bits per channel |
| halt_set | input | 1 | Sets the halt flag |
| halt_clr | input | 1 | Clears the halt flag |
| hoe_en | input | 1 | Halt on any error |
| dbg_en | input | 1 | Enables the debug stall input |
| dbg_stall | input | 1 | Debug stall request |
| clm_en | input | 1 | Continuous self-link restart |
| ext_err | input | 1 | Transfer error pulse from the engine |
| done | input | 1 | Active channel finished its minor loop |
| link_self | input | 1 | Qualifies `done`: the channel links to itself |
| grant_vld | output | 1 | A channel is active |
| grant_ch | output | 5 | Active channel number |
| start | output | 1 | One-cycle start strobe |
| cfg_err | output | 1 | Duplicate-priority configuration error pulse |
| halted | output | 1 | Halt flag |

## Verification
Some properties are checked on every cycle by the assertions:
- a strobe never appears without an active grant, and a start only follows an idle cycle or a self-link restart;
- the granted number is stable while a channel runs;
- no grant rises after a cycle spent halted or debug-stalled;
- a configuration error never comes with a grant, and it raises the halt flag when halt-on-error is set;
- a continuous restart repeats the same channel.

Other behaviour can only be shown by the bench's scenarios: which channel wins under each priority pattern, the circular order and per-group independence of the round-robin pointers, and the reposted request of a non-continuous self-link.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  // Number of distinct pairs among n entries (size of a duplicate scan).
  function automatic int pair_count(input int n);
    return (n * (n - 1)) / 2;
  endfunction

endpackage

// File: rtl/arb_pick.sv
`timescale 1ns/1ps
// One arbitration stage: fixed priority (larger level wins, lowest index on tie)
// or round robin starting after the last granted index.
module arb_pick #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] pri,
  input  logic            rr_en,
  input  logic [IW-1:0]   ptr,
  output logic            any,
  output logic [IW-1:0]   win
);

  function automatic logic [IW-1:0] fixed_pick(input logic [N-1:0] r,
                                                input logic [N*PW-1:0] p);
    logic [PW-1:0] best;
    logic [IW-1:0] idx;
    logic          found;
    best  = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (r[i] && (!found || p[i*PW +: PW] > best)) begin
        best  = p[i*PW +: PW];
        idx   = IW'(i);
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  function automatic logic [IW-1:0] rr_pick(input logic [N-1:0] r,
                                             input logic [IW-1:0] last);
    logic [IW-1:0] idx;
    logic [IW-1:0] cand;
    logic          found;
    idx   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last) + k) % N);
      if (!found && r[cand]) begin
        idx   = cand;
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  logic [IW-1:0] fixed_win;
  logic [IW-1:0] rr_win;

  always_comb begin
    any       = |req;
    fixed_win = fixed_pick(req, pri);
    rr_win    = rr_pick(req, ptr);
    win       = rr_en ? rr_win : fixed_win;
  end

endmodule

// File: rtl/pri_dup.sv
`timescale 1ns/1ps
// Flags any pair of equal priority levels among N entries.
module pri_dup #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic [N*PW-1:0] pri,
  output logic            dup
);

  localparam int PAIRS = dma_arb_pkg::pair_count(N);

  function automatic logic has_dup(input logic [N*PW-1:0] p);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (p[i*PW +: PW] == p[j*PW +: PW]) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  always_comb dup = (PAIRS > 0) && has_dup(pri);

endmodule

// File: rtl/dma_grp_arbiter.sv
`timescale 1ns/1ps
module dma_grp_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_GRP      = 4,
  parameter int CH_PER_GRP = 8,
  parameter int GPRI_W     = 2,
  parameter int CPRI_W     = 3,
  localparam int N_CH   = N_GRP * CH_PER_GRP,
  localparam int GIDX_W = $clog2(N_GRP),
  localparam int CIDX_W = $clog2(CH_PER_GRP),
  localparam int CH_W   = GIDX_W + CIDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          req,
  input  logic                     grp_rr_en,
  input  logic                     ch_rr_en,
  input  logic [N_GRP*GPRI_W-1:0]  grp_pri,
  input  logic [N_CH*CPRI_W-1:0]   ch_pri,
  input  logic                     halt_set,
  input  logic                     halt_clr,
  input  logic                     hoe_en,
  input  logic                     dbg_en,
  input  logic                     dbg_stall,
  input  logic                     clm_en,
  input  logic                     ext_err,
  input  logic                     done,
  input  logic                     link_self,
  output logic                     grant_vld,
  output logic [CH_W-1:0]          grant_ch,
  output logic                     start,
  output logic                     cfg_err,
  output logic                     halted
);

  // ---------------- state ----------------
  arb_state_e          state_q;
  logic [CH_W-1:0]     cur_ch_q;
  logic                start_q;
  logic                cfg_err_q;
  logic                halt_q;
  logic [GIDX_W-1:0]   grp_ptr_q;
  logic [CIDX_W-1:0]   ch_ptr_q [N_GRP];
  logic [N_CH-1:0]     link_pend_q;

  // ---------------- named internal events ----------------
  logic [N_CH-1:0]     eff_req;
  logic [N_GRP-1:0]    grp_any;
  logic [CIDX_W-1:0]   ch_win [N_GRP];
  logic [N_GRP-1:0]    ch_dup;
  logic                grp_dup;
  logic                any_req;
  logic [GIDX_W-1:0]   sel_grp;
  logic [CH_W-1:0]     sel_ch;
  logic                cfg_dup;
  logic                stall;
  logic                idle;
  logic                arb_try;
  logic                arb_fire;
  logic                cfg_evt;
  logic                restart;
  logic                finish;
  logic                relink;
  logic                err_evt;

  assign eff_req = req | link_pend_q;

  // Second stage: one channel picker and duplicate scan per group.
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    arb_pick #(.N(CH_PER_GRP), .PW(CPRI_W)) u_ch_pick (
      .req   (eff_req[g*CH_PER_GRP +: CH_PER_GRP]),
      .pri   (ch_pri[g*CH_PER_GRP*CPRI_W +: CH_PER_GRP*CPRI_W]),
      .rr_en (ch_rr_en),
      .ptr   (ch_ptr_q[g]),
      .any   (grp_any[g]),
      .win   (ch_win[g])
    );
    pri_dup #(.N(CH_PER_GRP), .PW(CPRI_W)) u_ch_dup (
      .pri (ch_pri[g*CH_PER_GRP*CPRI_W +: CH_PER_GRP*CPRI_W]),
      .dup (ch_dup[g])
    );
  end

  // First stage: group picker.
  arb_pick #(.N(N_GRP), .PW(GPRI_W)) u_grp_pick (
    .req   (grp_any),
    .pri   (grp_pri),
    .rr_en (grp_rr_en),
    .ptr   (grp_ptr_q),
    .any   (any_req),
    .win   (sel_grp)
  );

  pri_dup #(.N(N_GRP), .PW(GPRI_W)) u_grp_dup (
    .pri (grp_pri),
    .dup (grp_dup)
  );

  always_comb begin
    sel_ch   = {sel_grp, ch_win[sel_grp]};
    cfg_dup  = (!grp_rr_en && grp_dup) || (!ch_rr_en && (|ch_dup));
    stall    = halt_q || (dbg_en && dbg_stall);
    idle     = (state_q == ARB_IDLE);
    arb_try  = idle && !stall && any_req;
    arb_fire = arb_try && !cfg_dup;
    cfg_evt  = arb_try && cfg_dup;
    restart  = !idle && done && link_self && clm_en;
    finish   = !idle && done && !restart;
    relink   = finish && link_self;
    err_evt  = cfg_evt || ext_err;
  end

  // ---------------- sequential ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      cur_ch_q  <= '0;
      start_q   <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      start_q   <= arb_fire || restart;
      cfg_err_q <= cfg_evt;
      if (arb_fire) begin
        state_q  <= ARB_BUSY;
        cur_ch_q <= sel_ch;
      end else if (finish) begin
        state_q  <= ARB_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (halt_set || (hoe_en && err_evt)) begin
      halt_q <= 1'b1;
    end else if (halt_clr) begin
      halt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_ptr_q <= '1;
      for (int g = 0; g < N_GRP; g++) ch_ptr_q[g] <= '1;
    end else if (arb_fire) begin
      grp_ptr_q         <= sel_grp;
      ch_ptr_q[sel_grp] <= ch_win[sel_grp];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_pend_q <= '0;
    end else if (relink) begin
      link_pend_q[cur_ch_q] <= 1'b1;
    end else if (arb_fire) begin
      link_pend_q[sel_ch] <= 1'b0;
    end
  end

  assign grant_vld = (state_q == ARB_BUSY);
  assign grant_ch  = cur_ch_q;
  assign start     = start_q;
  assign cfg_err   = cfg_err_q;
  assign halted    = halt_q;

  // ---------------- assertions ----------------
  a_r6_start_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> grant_vld);

  a_r6_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($past(state_q) == ARB_IDLE) || $past(done && link_self && clm_en));

  a_r6_channel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !start) |-> $stable(grant_ch));

  a_r8_no_grant_halted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> !$past(halted));

  a_r10_no_grant_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> !$past(dbg_en && dbg_stall));

  a_r7_err_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !grant_vld && !start);

  a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(hoe_en)) |-> halted);

  a_r11_same_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $past(grant_vld && done && link_self && clm_en) |->
      (start && grant_vld && grant_ch == $past(grant_ch)));

endmodule

// File: tb/dma_grp_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_grp_arbiter_tb_top;

  localparam int NG  = 4;
  localparam int CPG = 8;
  localparam int NC  = NG * CPG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] req = '0;
  logic          grp_rr_en = 1'b0, ch_rr_en = 1'b0;
  logic [NG*2-1:0] grp_pri = '0;
  logic [NC*3-1:0] ch_pri = '0;
  logic          halt_set = 1'b0, halt_clr = 1'b0, hoe_en = 1'b0;
  logic          dbg_en = 1'b0, dbg_stall = 1'b0, clm_en = 1'b0;
  logic          ext_err = 1'b0, done = 1'b0, link_self = 1'b0;
  logic          grant_vld, start, cfg_err, halted;
  logic [4:0]    grant_ch;

  int n_chk = 0;
  int n_bad = 0;
  int gp[NG];
  int cp[NC];

  always #5 clk = ~clk;

  dma_grp_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .grp_rr_en(grp_rr_en), .ch_rr_en(ch_rr_en),
    .grp_pri(grp_pri), .ch_pri(ch_pri), .halt_set(halt_set), .halt_clr(halt_clr),
    .hoe_en(hoe_en), .dbg_en(dbg_en), .dbg_stall(dbg_stall), .clm_en(clm_en),
    .ext_err(ext_err), .done(done), .link_self(link_self), .grant_vld(grant_vld),
    .grant_ch(grant_ch), .start(start), .cfg_err(cfg_err), .halted(halted)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_pri();
    for (int g = 0; g < NG; g++) grp_pri[g*2 +: 2] = 2'(gp[g]);
    for (int n = 0; n < NC; n++) ch_pri[n*3 +: 3] = 3'(cp[n]);
  endtask

  task automatic base_pri();
    for (int g = 0; g < NG; g++) gp[g] = g;
    for (int n = 0; n < NC; n++) cp[n] = n % CPG;
    apply_pri();
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    req = '0; grp_rr_en = 0; ch_rr_en = 0; halt_set = 0; halt_clr = 0;
    hoe_en = 0; dbg_en = 0; dbg_stall = 0; clm_en = 0; ext_err = 0;
    done = 0; link_self = 0;
    base_pri();
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  // Reference model for fixed priority at both stages.
  function automatic int exp_fixed(input logic [NC-1:0] r);
    int bg = -1;
    int bc = -1;
    for (int g = 0; g < NG; g++)
      if (|r[g*CPG +: CPG])
        if (bg < 0 || gp[g] > gp[bg]) bg = g;
    if (bg < 0) return -1;
    for (int c = 0; c < CPG; c++)
      if (r[bg*CPG + c])
        if (bc < 0 || cp[bg*CPG + c] > cp[bg*CPG + bc]) bc = c;
    return bg * CPG + bc;
  endfunction

  // Assumes idle at a negedge with inputs applied.
  task automatic arb_once(input int exp, input string rq);
    tick();
    chk(rq, "start", 32'(start), 1);
    chk(rq, "grant_ch", 32'(grant_ch), 32'(exp));
    tick();
    chk("R6", "start pulse ends", 32'(start), 0);
    chk("R6", "grant held", 32'(grant_vld), 1);
    done = 1'b1;
    tick();
    done = 1'b0;
    chk("R6", "idle after done", 32'(grant_vld), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    reset_dut();
    // R1 reset state
    chk("R1", "grant_vld", 32'(grant_vld), 0);
    chk("R1", "start", 32'(start), 0);
    chk("R1", "cfg_err", 32'(cfg_err), 0);
    chk("R1", "halted", 32'(halted), 0);

    // R3: channel-level fixed priority, rotated levels in each group
    for (int g = 0; g < NG; g++) begin
      for (int s = 0; s < CPG; s++) begin
        for (int n = 0; n < NC; n++) cp[n] = ((n % CPG) + s) % CPG;
        apply_pri();
        req = 32'hFF << (g * CPG);
        arb_once(exp_fixed(req), "R3");
      end
    end
    req = '0;

    // R2: group-level fixed priority, rotated group levels
    for (int s = 0; s < NG; s++) begin
      for (int g = 0; g < NG; g++) gp[g] = (g + s) % NG;
      for (int n = 0; n < NC; n++) cp[n] = n % CPG;
      apply_pri();
      req = '1;
      arb_once(exp_fixed(req), "R2");
      req = 32'h00FF_00FF;
      arb_once(exp_fixed(req), "R2");
    end
    req = '0;

    // R4: round robin among groups
    reset_dut();
    grp_rr_en = 1'b1;
    req = '1;
    for (int k = 0; k < 5; k++) arb_once((k % NG) * CPG + 7, "R4");
    reset_dut();
    grp_rr_en = 1'b1;
    req = 32'hFF00_FF00;
    arb_once(15, "R4");
    arb_once(31, "R4");
    arb_once(15, "R4");

    // R5: round robin inside a group
    reset_dut();
    ch_rr_en = 1'b1;
    req = 32'h00FF_0000;
    for (int k = 0; k < 9; k++) arb_once(16 + (k % CPG), "R5");
    reset_dut();
    ch_rr_en = 1'b1;
    req = 32'h0000_0052;
    arb_once(1, "R5");
    arb_once(4, "R5");
    arb_once(6, "R5");
    arb_once(1, "R5");
    // R4 and R5 together: independent per-group pointers
    reset_dut();
    ch_rr_en = 1'b1;
    grp_rr_en = 1'b1;
    req = '1;
    for (int k = 0; k < 8; k++) arb_once((k % NG) * CPG + (k / NG), "R5");

    // R7: duplicate channel levels
    reset_dut();
    cp[1] = 0;
    apply_pri();
    req = 32'h4;
    tick();
    chk("R7", "cfg_err", 32'(cfg_err), 1);
    chk("R7", "no start", 32'(start), 0);
    chk("R7", "no grant", 32'(grant_vld), 0);
    tick();
    chk("R7", "cfg_err repeats", 32'(cfg_err), 1);
    ch_rr_en = 1'b1;
    arb_once(2, "R7");
    chk("R7", "no err in rr", 32'(cfg_err), 0);
    // R7: duplicate group levels
    reset_dut();
    for (int g = 0; g < NG; g++) gp[g] = 1;
    apply_pri();
    req = 32'h1000;
    tick();
    chk("R7", "grp cfg_err", 32'(cfg_err), 1);
    chk("R7", "grp no grant", 32'(grant_vld), 0);
    grp_rr_en = 1'b1;
    arb_once(12, "R7");

    // R8: halt
    reset_dut();
    halt_set = 1'b1;
    tick();
    halt_set = 1'b0;
    chk("R8", "halted set", 32'(halted), 1);
    req = 32'h20;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", "no start halted", 32'(start), 0);
      chk("R8", "no grant halted", 32'(grant_vld), 0);
    end
    halt_clr = 1'b1;
    tick();
    halt_clr = 1'b0;
    chk("R8", "halted clear", 32'(halted), 0);
    chk("R8", "not yet granted", 32'(grant_vld), 0);
    tick();
    chk("R8", "resume start", 32'(start), 1);
    chk("R8", "resume ch", 32'(grant_ch), 5);
    halt_set = 1'b1;
    tick();
    halt_set = 1'b0;
    chk("R8", "active keeps grant", 32'(grant_vld), 1);
    tick();
    chk("R8", "active keeps grant 2", 32'(grant_vld), 1);
    done = 1'b1;
    tick();
    done = 1'b0;
    tick();
    tick();
    chk("R8", "no restart halted", 32'(grant_vld), 0);
    halt_set = 1'b1;
    halt_clr = 1'b1;
    tick();
    halt_set = 1'b0;
    halt_clr = 1'b0;
    chk("R8", "set wins", 32'(halted), 1);
    halt_clr = 1'b1;
    tick();
    halt_clr = 1'b0;
    tick();
    chk("R8", "start after clear", 32'(start), 1);
    done = 1'b1;
    req = '0;
    tick();
    done = 1'b0;

    // R9: halt on error
    reset_dut();
    hoe_en = 1'b1;
    ext_err = 1'b1;
    tick();
    ext_err = 1'b0;
    chk("R9", "ext_err halts", 32'(halted), 1);
    halt_clr = 1'b1;
    tick();
    halt_clr = 1'b0;
    hoe_en = 1'b0;
    ext_err = 1'b1;
    tick();
    ext_err = 1'b0;
    chk("R9", "no halt without hoe", 32'(halted), 0);
    hoe_en = 1'b1;
    cp[1] = 0;
    apply_pri();
    req = 32'h8;
    tick();
    chk("R9", "cfg_err", 32'(cfg_err), 1);
    chk("R9", "cfg err halts", 32'(halted), 1);
    tick();
    chk("R9", "requests ignored", 32'(cfg_err), 0);
    chk("R9", "still idle", 32'(grant_vld), 0);

    // R10: debug stall
    reset_dut();
    dbg_en = 1'b1;
    dbg_stall = 1'b1;
    req = 32'h8;
    tick();
    tick();
    chk("R10", "stalled", 32'(grant_vld), 0);
    dbg_en = 1'b0;
    tick();
    chk("R10", "en cleared start", 32'(start), 1);
    chk("R10", "en cleared ch", 32'(grant_ch), 3);
    done = 1'b1;
    dbg_en = 1'b1;
    tick();
    done = 1'b0;
    chk("R10", "idle", 32'(grant_vld), 0);
    tick();
    chk("R10", "stalled again", 32'(grant_vld), 0);
    dbg_stall = 1'b0;
    tick();
    chk("R10", "stall released start", 32'(start), 1);
    done = 1'b1;
    req = '0;
    tick();
    done = 1'b0;

    // R11: continuous self-link
    reset_dut();
    clm_en = 1'b1;
    req = 32'h200;
    tick();
    chk("R11", "first start", 32'(start), 1);
    chk("R11", "first ch", 32'(grant_ch), 9);
    req = 32'h8000_0200;
    tick();
    done = 1'b1;
    link_self = 1'b1;
    tick();
    done = 1'b0;
    link_self = 1'b0;
    chk("R11", "restart strobe", 32'(start), 1);
    chk("R11", "restart grant", 32'(grant_vld), 1);
    chk("R11", "restart ch", 32'(grant_ch), 9);
    tick();
    done = 1'b1;
    tick();
    done = 1'b0;
    tick();
    chk("R11", "then arbitrates", 32'(grant_ch), 32'(exp_fixed(req)));
    done = 1'b1;
    req = '0;
    tick();
    done = 1'b0;

    // R12: self-link through arbitration
    reset_dut();
    req = 32'h1000;
    tick();
    chk("R12", "first ch", 32'(grant_ch), 12);
    req = '0;
    done = 1'b1;
    link_self = 1'b1;
    tick();
    done = 1'b0;
    link_self = 1'b0;
    chk("R12", "ends grant", 32'(grant_vld), 0);
    tick();
    chk("R12", "reposted start", 32'(start), 1);
    chk("R12", "reposted ch", 32'(grant_ch), 12);
    done = 1'b1;
    tick();
    done = 1'b0;
    tick();
    tick();
    chk("R12", "pending cleared", 32'(grant_vld), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule